// File: doc/BRIEF.md
# Performance Counter Unit

This block watches a running core and counts. It keeps three 32-bit counters: one counts clock cycles, the other two each count one event strobe taken from a 64-wide event bus. Each event counter picks its strobe with a 6-bit select. A single control word holds the selects, the enables, the overflow flags and the command bits. The unit raises one interrupt line when a counter wraps and the interrupt for that counter is enabled.

Software reaches the unit through a plain register port with a write strobe, a 2-bit address, write data and registered read data. Address 0 is the control word. Addresses 1, 2 and 3 give direct read and write access to the cycle counter, event counter 0 and event counter 1. The cycle counter can be slowed to one step every 64 enabled clocks so that it runs longer before it wraps. A command bit clears only the cycle counter, and another clears all three counters.

Top module: `perf_mon_unit`

## Requirements
- R1: After a synchronous reset every counter, every control field, the read data and the interrupt output are all zero.
- R2: The control word at address 0 holds these fields: event counter 1 select in bits 23:18, event counter 0 select in bits 17:12, the overflow flags in bits 10:8 (cycle, event 0, event 1), the interrupt enables in bits 6:4 (same order), the prescale bit in bit 3 and the global enable in bit 0. Bits 31:24, 11, 7, 2 and 1 read as zero. Writes to bits 31:24, 11 and 7 have no effect.
- R3: While the global enable bit is 0, no counter and no prescaler state changes, except through direct writes and clear commands.
- R4: While the unit is enabled, each event counter adds one in every clock in which event input bit [select] is high.
- R5: While the unit is enabled and bit 3 is 0, the cycle counter adds one every clock.
- R6: While bit 3 is 1, the cycle counter adds one once every 64 enabled clocks. The 6-bit prescale count advances only while the unit is enabled, and it is cleared whenever the cycle counter is cleared.
- R7: Writing 1 to bit 2 clears only the cycle counter. Writing 1 to bit 1 clears all three counters. A clear wins over an increment in the same clock.
- R8: A counter that steps from 0xFFFFFFFF wraps to 0 and sets its overflow flag at the same clock edge.
- R9: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. A wrap in the same clock as a clearing write leaves the flag set.
- R10: The interrupt output is 1 exactly when some flag and its matching enable are both 1.
- R11: A write to address 1, 2 or 3 loads the cycle, event 0 or event 1 counter with the write data. The load wins over an increment in the same clock.
- R12: The read data is registered. One clock after an address is presented, it shows the register at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | 64 | Event strobe vector |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every clock that each counter obeys its step rules. A clear gives zero, a load gives the written value, an increment gives the old value plus one, and no request leaves the value unchanged. They also check that a wrap always sets its flag, that a one-write clears flags when no wrap competes, and that the interrupt always matches the flags and enables. Some behaviour only the bench scenarios can show: selecting the right strobe from the event bus, the exact one-in-64 rate of the prescaled cycle count, the prescaler clear, and the priority of a clear or a load over an increment.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = DATA_W;
  localparam int SEL_W   = 6;
  localparam int NUM_EVT = 1 << SEL_W;
  localparam int PRE_W   = 6;
  localparam int NUM_CNT = 3;
  localparam int ADDR_W  = 2;

  // control word bit positions (software visible)
  localparam int EN_BIT      = 0;
  localparam int CLR_ALL_BIT = 1;
  localparam int CLR_CYC_BIT = 2;
  localparam int SCALE_BIT   = 3;
  localparam int IE_LO       = 4;
  localparam int FLAG_LO     = 8;
  localparam int SEL0_LO     = 12;
  localparam int SEL1_LO     = 18;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EV0  = 2'd2,
    RA_EV1  = 2'd3
  } reg_addr_e;

  // index 0: cycle counter, 1: event counter 0, 2: event counter 1
  typedef struct packed {
    logic [SEL_W-1:0]   sel1;
    logic [SEL_W-1:0]   sel0;
    logic [NUM_CNT-1:0] flag;
    logic [NUM_CNT-1:0] ie;
    logic               scale;
    logic               en;
  } ctrl_t;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = inc && !clr && !load && (&cnt_q);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (inc)  cnt_q <= cnt_q + W'(1);
  end

  AST_CNT_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R7
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (cnt_q == $past(load_val))); // R11
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !load) |=> (cnt_q == $past(cnt_q) + W'(1))); // R4
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr && !load) |=> $stable(cnt_q)); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/pm_prescale.sv
module pm_prescale #(
  parameter int PW = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [PW-1:0] pre_q;

  assign tick = run && (&pre_q);

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + PW'(1);
  end

  AST_PRE_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0)); // R6
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pre_q)); // R6
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import perfmon_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [SEL_W-1:0]   w_sel1,
  input  logic [SEL_W-1:0]   w_sel0,
  input  logic [NUM_CNT-1:0] w_flag,
  input  logic [NUM_CNT-1:0] w_ie,
  input  logic               w_scale,
  input  logic               w_clr_cyc,
  input  logic               w_clr_all,
  input  logic               w_en,
  input  logic [NUM_CNT-1:0] ovf,
  output ctrl_t              ctrl,
  output logic               clr_cyc,
  output logic               clr_evt,
  output logic               irq,
  output logic [DATA_W-1:0]  rd_word
);
  ctrl_t ctrl_q, ctrl_d;
  logic  irq_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d.sel1  = w_sel1;
      ctrl_d.sel0  = w_sel0;
      ctrl_d.ie    = w_ie;
      ctrl_d.scale = w_scale;
      ctrl_d.en    = w_en;
      ctrl_d.flag  = ctrl_q.flag & ~w_flag;
    end
    // a wrap in the same clock outranks a clearing write
    ctrl_d.flag = ctrl_d.flag | ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= |(ctrl_d.flag & ctrl_d.ie);
    end
  end

  assign clr_evt = wr && w_clr_all;
  assign clr_cyc = wr && (w_clr_all || w_clr_cyc);
  assign ctrl    = ctrl_q;
  assign irq     = irq_q;

  always_comb begin
    rd_word = '0;
    rd_word[SEL1_LO +: SEL_W]   = ctrl_q.sel1;
    rd_word[SEL0_LO +: SEL_W]   = ctrl_q.sel0;
    rd_word[FLAG_LO +: NUM_CNT] = ctrl_q.flag;
    rd_word[IE_LO +: NUM_CNT]   = ctrl_q.ie;
    rd_word[SCALE_BIT]          = ctrl_q.scale;
    rd_word[EN_BIT]             = ctrl_q.en;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (ovf != '0) |=> ((ctrl_q.flag & $past(ovf)) == $past(ovf))); // R8
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr && (ovf == '0)) |=> ((ctrl_q.flag & $past(w_flag)) == '0)); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!wr && (ovf == '0)) |=> $stable(ctrl_q.flag)); // R9
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(ctrl_q.flag & ctrl_q.ie)); // R10
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import perfmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic              irq
);
  ctrl_t              ctrl;
  logic               clr_cyc, clr_evt, tick, wr_ctrl;
  logic [NUM_CNT-1:0] inc, clr, load, ovf;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [DATA_W-1:0]  ctrl_word, rdata_q;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);

  pm_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_ctrl),
    .w_sel1    (reg_wdata[SEL1_LO +: SEL_W]),
    .w_sel0    (reg_wdata[SEL0_LO +: SEL_W]),
    .w_flag    (reg_wdata[FLAG_LO +: NUM_CNT]),
    .w_ie      (reg_wdata[IE_LO +: NUM_CNT]),
    .w_scale   (reg_wdata[SCALE_BIT]),
    .w_clr_cyc (reg_wdata[CLR_CYC_BIT]),
    .w_clr_all (reg_wdata[CLR_ALL_BIT]),
    .w_en      (reg_wdata[EN_BIT]),
    .ovf       (ovf),
    .ctrl      (ctrl),
    .clr_cyc   (clr_cyc),
    .clr_evt   (clr_evt),
    .irq       (irq),
    .rd_word   (ctrl_word)
  );

  pm_prescale #(.PW(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl.en),
    .clr  (clr_cyc),
    .tick (tick)
  );

  assign inc[0] = ctrl.en && (ctrl.scale ? tick : 1'b1);
  assign inc[1] = ctrl.en && evt_in[ctrl.sel0];
  assign inc[2] = ctrl.en && evt_in[ctrl.sel1];
  assign clr[0] = clr_cyc;
  assign clr[1] = clr_evt;
  assign clr[2] = clr_evt;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign load[i] = reg_wr && (reg_addr == ADDR_W'(i + 1));
    pm_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr[i]),
      .load     (load[i]),
      .load_val (reg_wdata[CNT_W-1:0]),
      .inc      (inc[i]),
      .cnt      (cnt[i]),
      .wrap     (ovf[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (reg_addr)
        RA_CTRL: rdata_q <= ctrl_word;
        RA_CYC:  rdata_q <= cnt[0];
        RA_EV0:  rdata_q <= cnt[1];
        default: rdata_q <= cnt[2];
      endcase
    end
  end

  assign reg_rdata = rdata_q;

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[31:24] == '0) && !ctrl_word[11] && !ctrl_word[7] && (ctrl_word[2:1] == '0)); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |-> (ovf == '0)); // R3
endmodule

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  s0;
    logic [5:0]  s1;
    logic [63:0] ev;
    logic [7:0]  k;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{6'd0,  6'd1,  64'h0000_0000_0000_0001, 8'd10},
    '{6'd63, 6'd62, 64'hC000_0000_0000_0000, 8'd17},
    '{6'd5,  6'd40, 64'h0000_0100_0000_0000, 8'd25},
    '{6'd32, 6'd31, 64'h0000_0001_8000_0000, 8'd3},
    '{6'd7,  6'd7,  64'hFFFF_FFFF_FFFF_FFFF, 8'd1},
    '{6'd12, 6'd13, 64'h0000_0000_0000_1000, 8'd50}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] evt_in = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  perf_mon_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exactly k counting clocks with control fields "base"
  task automatic run(input logic [31:0] base, input int k);
    wr(2'd0, base | 32'h1);
    idle(k - 1);
    wr(2'd0, base);
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
      finish_up();
    end
  end

  initial begin
    logic [31:0] v, base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset read", v, 32'h0);
    end

    // R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      base = (32'(VEC[i].s1) << 18) | (32'(VEC[i].s0) << 12);
      wr(2'd0, base | 32'h2);
      evt_in = VEC[i].ev;
      run(base, int'(VEC[i].k));
      evt_in = '0;
      rd(2'd1, v); chk("R5 cycle count", v, 32'(VEC[i].k));
      rd(2'd2, v); chk("R4 event0 count", v, VEC[i].ev[VEC[i].s0] ? 32'(VEC[i].k) : 32'h0);
      rd(2'd3, v); chk("R4 event1 count", v, VEC[i].ev[VEC[i].s1] ? 32'(VEC[i].k) : 32'h0);
    end

    // R2 layout and reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 all-ones readback", v, 32'h00FF_F079);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'hFF00_0882);
    rd(2'd0, v); chk("R2 reserved bits", v, 32'h0);

    // R11 direct load and readback
    wr(2'd2, 32'h1234_5678);
    wr(2'd3, 32'hA5A5_0F0F);
    rd(2'd2, v); chk("R11 load event0", v, 32'h1234_5678);
    rd(2'd3, v); chk("R11 load event1", v, 32'hA5A5_0F0F);
    rd(2'd0, v); chk("R12 read after addr", v, 32'h0);

    // R3 disabled: nothing counts
    wr(2'd1, 32'h100);
    wr(2'd2, 32'h200);
    evt_in = '1;
    idle(10);
    evt_in = '0;
    rd(2'd1, v); chk("R3 cycle held", v, 32'h100);
    rd(2'd2, v); chk("R3 event0 held", v, 32'h200);

    // R11 load wins over increment
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h55);
    wr(2'd0, 32'h0);
    rd(2'd1, v); chk("R11 load beats inc", v, 32'h56);

    // R7 clear commands
    wr(2'd1, 32'h111); wr(2'd2, 32'h222); wr(2'd3, 32'h333);
    wr(2'd0, 32'h4);
    rd(2'd1, v); chk("R7 cycle cleared", v, 32'h0);
    rd(2'd2, v); chk("R7 event0 kept", v, 32'h222);
    rd(2'd3, v); chk("R7 event1 kept", v, 32'h333);
    wr(2'd0, 32'h2);
    rd(2'd2, v); chk("R7 event0 cleared", v, 32'h0);
    rd(2'd3, v); chk("R7 event1 cleared", v, 32'h0);
    evt_in = '1;
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h3);
    wr(2'd0, 32'h0);
    evt_in = '0;
    rd(2'd1, v); chk("R7 clear beats inc cycle", v, 32'h1);
    rd(2'd2, v); chk("R7 clear beats inc event0", v, 32'h1);

    // R6 prescaled cycle counting
    wr(2'd0, 32'hC);
    run(32'h8, 63);
    rd(2'd1, v); chk("R6 63 clocks", v, 32'h0);
    run(32'h8, 1);
    rd(2'd1, v); chk("R6 64 clocks", v, 32'h1);
    run(32'h8, 128);
    rd(2'd1, v); chk("R6 192 clocks", v, 32'h3);
    run(32'h8, 40);
    wr(2'd0, 32'hC);
    run(32'h8, 63);
    rd(2'd1, v); chk("R6 prescaler cleared", v, 32'h0);
    run(32'h8, 1);
    rd(2'd1, v); chk("R6 tick after clear", v, 32'h1);

    // R8 R9 R10 cycle counter wrap
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFFFF_FFFE);
    run(32'h10, 2);
    rd(2'd1, v); chk("R8 cycle wraps to 0", v, 32'h0);
    chk("R10 irq on enabled flag", {31'd0, irq}, 32'h1);
    rd(2'd0, v); chk("R8 cycle flag", v, 32'h110);
    wr(2'd0, 32'h10);
    rd(2'd0, v); chk("R9 zero write keeps flag", v, 32'h110);
    chk("R10 irq stays", {31'd0, irq}, 32'h1);
    wr(2'd0, 32'h110);
    rd(2'd0, v); chk("R9 one write clears flag", v, 32'h10);
    chk("R10 irq drops", {31'd0, irq}, 32'h0);

    // R8 R10 event1 wrap, masked then enabled
    wr(2'd0, 32'h5 << 18);
    wr(2'd3, 32'hFFFF_FFFF);
    evt_in = 64'h20;
    run(32'h5 << 18, 1);
    evt_in = '0;
    rd(2'd3, v); chk("R8 event1 wraps", v, 32'h0);
    rd(2'd0, v); chk("R8 event1 flag", v, 32'h0014_0400);
    chk("R10 masked irq", {31'd0, irq}, 32'h0);
    wr(2'd0, (32'h5 << 18) | 32'h40);
    idle(1);
    chk("R10 enable raises irq", {31'd0, irq}, 32'h1);
    wr(2'd0, (32'h5 << 18) | 32'h440);
    chk("R10 clear lowers irq", {31'd0, irq}, 32'h0);

    // R8 event0 wrap
    wr(2'd2, 32'hFFFF_FFFF);
    evt_in = 64'h200;
    run((32'h9 << 12) | 32'h20, 1);
    evt_in = '0;
    rd(2'd0, v); chk("R8 event0 flag", v, 32'h0000_9220);
    chk("R10 event0 irq", {31'd0, irq}, 32'h1);
    wr(2'd0, 32'h200);

    // R9 wrap outranks a clearing write in the same clock
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h100);
    rd(2'd0, v); chk("R9 set beats clear", v, 32'h100);
    wr(2'd0, 32'h100);
    rd(2'd0, v); chk("R9 later clear", v, 32'h0);

    done = 1'b1;
    finish_up();
  end
endmodule